// File: doc/BRIEF.md
# Beat-Tone Frequency Locking Loop Controller

This block is the digital heart of a loop that steers a voltage-controlled crystal oscillator. An analog mixer compares that oscillator with a stable reference, and its squared difference tone arrives on `beat_in`. The block synchronises the tone and counts its rising edges over a fixed window of system-clock cycles. It compares the count with a setpoint and integrates the signed difference into an unsigned control word that drives an external DAC. The setpoint is a nominal count plus one of two programmable offsets, either the receive offset or the transmit offset. The loop therefore settles on the reference plus a chosen offset, not on zero beat error.

Modulation samples are captured on a strobe and applied at two places. They shift the setpoint, which the integrator follows slowly. They are also added straight onto the control word, which gives the fast path. Together the two paths keep the modulation response flat across the loop's own bandwidth. A hold input freezes the control word. This keeps the oscillator steady over short open-loop intervals, for example on wake from a power-save state. A lock flag reports that the error has stayed small over several consecutive windows.

Top module: `beat_lock_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets `ctrl_word` to mid-scale (2^(CW-1)) and clears `locked` and `gate_vld`. It also sets the integrator to mid-scale and the held modulation sample to zero.
- R2: Rising edges of `beat_in` are counted over windows of exactly GATE_CYC clock cycles. The first counted edge is taken after a two-flop synchroniser. At the end of each window, `err_out` presents setpoint minus count, where setpoint = TARGET + selected offset + held modulation sample.
- R3: `tx_mode` = 0 selects `off_rx` as the offset, and `tx_mode` = 1 selects `off_tx`. Both offsets are signed two's-complement words.
- R4: In the cycle after `gate_vld`, the integrator adds `err_out` arithmetically shifted right by KSH. `ctrl_word` shows the new value one cycle later.
- R5: The integrator and `ctrl_word` clip at 0 and at 2^CW-1. They never wrap.
- R6: `mod_stb` captures `mod_in`. Two cycles after the strobe, `ctrl_word` equals the integrator plus that sample. The same sample is part of the setpoint of every later window. A change on `mod_in` without a strobe has no effect.
- R7: While `hold` is high, `ctrl_word` does not change and the integrator ignores window results. One cycle after `hold` falls, `ctrl_word` again equals the clipped sum of the integrator and the held sample.
- R8: `locked` rises one cycle after the `gate_vld` of the LOCK_N-th consecutive window with |`err_out`| ≤ LOCK_THR. A window outside that bound clears the flag one cycle after its `gate_vld`.
- R9: Any change of `tx_mode`, `off_rx` or `off_tx` clears `locked` in the next cycle and restarts the count of good windows.
- R10: `gate_vld` is a single-cycle pulse, one per window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_in | input | 1 | Asynchronous squared beat tone |
| tx_mode | input | 1 | Offset select: 0 receive, 1 transmit |
| off_rx | input | OW | Signed receive offset, in counts per window |
| off_tx | input | OW | Signed transmit offset, in counts per window |
| hold | input | 1 | Open-loop freeze of the control word |
| mod_stb | input | 1 | Modulation sample strobe |
| mod_in | input | MW | Signed modulation sample |
| ctrl_word | output | CW | Unsigned DAC control word |
| err_out | output | OW+4 | Signed error of the last window |
| gate_vld | output | 1 | Pulse marking a new `err_out` |
| locked | output | 1 | Lock indication |

## Verification
The bench uses GATE_CYC = 240, TARGET = 30, CW = 8, KSH = 0, LOCK_N = 3 and LOCK_THR = 1. Beat periods of 8 and 12 cycles divide the window evenly, so each full window counts exactly 30 or 20 edges and every error value is exact. The 8-bit control word and unit gain let an offset of ±100 drive the integrator into both clip limits within a few windows. The short lock count brings the rise and fall of the lock flag within a few windows.

// File: rtl/beat_lock_ctrl.sv
`timescale 1ns/1ps
module beat_lock_ctrl #(
  parameter int GATE_CYC = 4000,
  parameter int TARGET   = 1000,
  parameter int OW       = 14,
  parameter int MW       = 12,
  parameter int CW       = 12,
  parameter int KSH      = 4,
  parameter int LOCK_THR = 2,
  parameter int LOCK_N   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 beat_in,
  input  logic                 tx_mode,
  input  logic signed [OW-1:0] off_rx,
  input  logic signed [OW-1:0] off_tx,
  input  logic                 hold,
  input  logic                 mod_stb,
  input  logic signed [MW-1:0] mod_in,
  output logic [CW-1:0]        ctrl_word,
  output logic signed [OW+3:0] err_out,
  output logic                 gate_vld,
  output logic                 locked
);
  localparam int EW   = OW + 4;
  localparam int GW   = $clog2(GATE_CYC);
  localparam int CNTW = $clog2(GATE_CYC + 1);
  localparam int RW   = $clog2(LOCK_N + 1);
  localparam int SW   = CW + EW + 1;
  localparam int MAXC = (1 << CW) - 1;
  localparam logic [CW-1:0] MID = CW'(1 << (CW - 1));

  logic [2:0]             sync_q;
  logic [GW-1:0]          gcnt;
  logic [CNTW-1:0]        ecnt;
  logic signed [MW-1:0]   mod_q;
  logic [CW-1:0]          integ;
  logic [RW-1:0]          run;
  logic                   mode_q;
  logic signed [OW-1:0]   rxo_q, txo_q;

  wire                    edge_w   = sync_q[1] & ~sync_q[2];
  wire                    gate_end = gcnt == GW'(GATE_CYC - 1);
  wire [CNTW-1:0]         meas     = ecnt + CNTW'(edge_w);
  wire signed [OW-1:0]    off_sel  = tx_mode ? off_tx : off_rx;
  wire signed [EW-1:0]    setpt    = EW'(TARGET) + EW'(off_sel) + EW'(mod_q);
  wire signed [EW-1:0]    err_nx   = setpt - $signed({{(EW-CNTW){1'b0}}, meas});
  wire signed [SW-1:0]    isum     = $signed({{(SW-CW){1'b0}}, integ}) + SW'(err_out >>> KSH);
  wire signed [SW-1:0]    osum     = $signed({{(SW-CW){1'b0}}, integ}) + SW'(mod_q);
  wire                    chg      = (tx_mode != mode_q) || (off_rx != rxo_q) || (off_tx != txo_q);
  wire                    lock_ok  = (err_out <= EW'(LOCK_THR)) && (err_out >= -EW'(LOCK_THR));

  assign locked = run == RW'(LOCK_N);

  function automatic logic [CW-1:0] clip(input logic signed [SW-1:0] v);
    if (v < 0) return '0;
    if (v > SW'(MAXC)) return CW'(MAXC);
    return v[CW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    mode_q <= tx_mode;
    rxo_q  <= off_rx;
    txo_q  <= off_tx;
    if (rst) begin
      sync_q    <= '0;
      gcnt      <= '0;
      ecnt      <= '0;
      err_out   <= '0;
      gate_vld  <= 1'b0;
      mod_q     <= '0;
      integ     <= MID;
      ctrl_word <= MID;
      run       <= '0;
    end else begin
      sync_q   <= {sync_q[1:0], beat_in};
      gate_vld <= gate_end;
      if (gate_end) begin
        gcnt    <= '0;
        ecnt    <= '0;
        err_out <= err_nx;
      end else begin
        gcnt <= gcnt + GW'(1);
        ecnt <= meas;
      end
      if (mod_stb) mod_q <= mod_in;
      if (!hold) begin
        if (gate_vld) integ <= clip(isum);
        ctrl_word <= clip(osum);
      end
      if (chg) run <= '0;
      else if (gate_vld) begin
        if (!lock_ok) run <= '0;
        else if (!locked) run <= run + RW'(1);
      end
    end
  end
endmodule

module beat_lock_ctrl_chk #(
  parameter int CW = 12,
  parameter int OW = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 hold,
  input logic                 tx_mode,
  input logic signed [OW-1:0] off_rx,
  input logic signed [OW-1:0] off_tx,
  input logic [CW-1:0]        ctrl_word,
  input logic                 gate_vld,
  input logic                 locked
);
  localparam logic [CW-1:0] MID = CW'(1 << (CW - 1));

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (ctrl_word == MID && !locked && !gate_vld));

  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(ctrl_word));

  a_r8_lock_after_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(gate_vld));

  a_r9_lock_drop: assert property (@(posedge clk) disable iff (rst)
    (tx_mode != $past(tx_mode) || off_rx != $past(off_rx) || off_tx != $past(off_tx)) |=> !locked);

  a_r10_gate_pulse: assert property (@(posedge clk) disable iff (rst)
    gate_vld |=> !gate_vld);
endmodule

bind beat_lock_ctrl beat_lock_ctrl_chk #(.CW(CW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .tx_mode(tx_mode), .off_rx(off_rx),
  .off_tx(off_tx), .ctrl_word(ctrl_word), .gate_vld(gate_vld), .locked(locked)
);

// File: tb/test_beat_lock_ctrl.sv
`timescale 1ns/1ps
module test_beat_lock_ctrl;
  localparam int CLK  = 10;
  localparam int GATE = 240;
  localparam int TGT  = 30;
  localparam int CWB  = 8;
  localparam int OWB  = 14;
  localparam int MWB  = 12;
  localparam int MIDB = 128;

  logic clk = 0, rst = 1, beat = 0, tx_mode = 0, hold = 0, mod_stb = 0;
  logic signed [OWB-1:0] off_rx = 0, off_tx = 0;
  logic signed [MWB-1:0] mod_in = 0;
  wire  [CWB-1:0]        ctrl;
  wire  signed [OWB+3:0] err;
  wire                   gate_vld, locked;

  int checks = 0, errors = 0;
  int per = 8, bc = 0;
  int exp_i = MIDB, mod_cur = 0;

  beat_lock_ctrl #(.GATE_CYC(GATE), .TARGET(TGT), .OW(OWB), .MW(MWB), .CW(CWB),
                   .KSH(0), .LOCK_THR(1), .LOCK_N(3)) i_beat_lock_ctrl (
    .clk(clk), .rst(rst), .beat_in(beat), .tx_mode(tx_mode), .off_rx(off_rx),
    .off_tx(off_tx), .hold(hold), .mod_stb(mod_stb), .mod_in(mod_in),
    .ctrl_word(ctrl), .err_out(err), .gate_vld(gate_vld), .locked(locked));

  always #(CLK/2) clk = ~clk;

  always @(negedge clk) begin
    bc = (bc + 1) % per;
    beat = bc < per / 2;
  end

  function automatic int satb(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  always @(negedge clk) begin
    #(CLK/4);
    if (rst) exp_i = MIDB;
    else if (gate_vld && !hold) exp_i = satb(exp_i + int'(err));
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wait_gate;
    @(negedge clk);
    while (!gate_vld) @(negedge clk);
  endtask

  task automatic strobe(input int v);
    @(negedge clk); mod_stb = 1; mod_in = MWB'(v);
    @(negedge clk); mod_stb = 0; mod_cur = v;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(int'(ctrl) == MIDB, "R1 ctrl", int'(ctrl), MIDB);
    chk(!locked, "R1 locked", int'(locked), 0);
    rst = 0;
    @(negedge clk);
    chk(int'(ctrl) == MIDB, "R1 ctrl after release", int'(ctrl), MIDB);
    chk(!gate_vld, "R1 gate_vld", int'(gate_vld), 0);
  endtask

  task automatic t_measure;
    int n;
    wait_gate; wait_gate;
    chk(int'(err) == 0, "R2 err period 8", int'(err), 0);
    @(negedge clk);
    chk(!gate_vld, "R10 single pulse", int'(gate_vld), 0);
    n = 1;
    while (!gate_vld) begin @(negedge clk); n++; end
    chk(n == GATE, "R2 window length", n, GATE);
    per = 12;
    wait_gate; wait_gate;
    chk(int'(err) == 10, "R2 err period 12", int'(err), 10);
  endtask

  task automatic t_integrate;
    int c0;
    wait_gate;
    c0 = int'(ctrl);
    chk(int'(err) == 10, "R4 err", int'(err), 10);
    @(negedge clk);
    chk(int'(ctrl) == c0, "R4 no early update", int'(ctrl), c0);
    @(negedge clk);
    chk(int'(ctrl) == satb(c0 + 10), "R4 ctrl step", int'(ctrl), satb(c0 + 10));
    chk(int'(ctrl) == exp_i, "R4 model", int'(ctrl), exp_i);
  endtask

  task automatic t_offset;
    per = 8;
    wait_gate;
    off_rx = 5; off_tx = -7; tx_mode = 0;
    wait_gate;
    chk(int'(err) == 5, "R3 receive offset", int'(err), 5);
    tx_mode = 1;
    wait_gate;
    chk(int'(err) == -7, "R3 transmit offset", int'(err), -7);
    tx_mode = 0; off_rx = 0; off_tx = 0;
  endtask

  task automatic t_saturate;
    wait_gate;
    off_rx = 100;
    for (int i = 0; i < 4; i++) begin
      wait_gate; repeat (2) @(negedge clk);
      chk(int'(ctrl) == exp_i, "R5 climb", int'(ctrl), exp_i);
    end
    chk(int'(ctrl) == 255, "R5 top clip", int'(ctrl), 255);
    off_rx = -100;
    for (int i = 0; i < 4; i++) begin
      wait_gate; repeat (2) @(negedge clk);
      chk(int'(ctrl) == exp_i, "R5 fall", int'(ctrl), exp_i);
    end
    chk(int'(ctrl) == 0, "R5 bottom clip", int'(ctrl), 0);
    off_rx = 64;
    wait_gate; wait_gate;
    off_rx = 0;
    repeat (2) @(negedge clk);
    chk(int'(ctrl) == 128, "R5 recover", int'(ctrl), 128);
  endtask

  task automatic t_mod;
    int c0;
    wait_gate;
    strobe(20);
    @(negedge clk);
    chk(int'(ctrl) == satb(exp_i + 20), "R6 direct path", int'(ctrl), satb(exp_i + 20));
    c0 = int'(ctrl);
    mod_in = 50;
    repeat (2) @(negedge clk);
    chk(int'(ctrl) == c0, "R6 no strobe ignored", int'(ctrl), c0);
    wait_gate;
    chk(int'(err) == 20, "R6 setpoint path", int'(err), 20);
    repeat (2) @(negedge clk);
    chk(int'(ctrl) == satb(exp_i + 20), "R6 integrated", int'(ctrl), satb(exp_i + 20));
    strobe(0);
    wait_gate;
  endtask

  task automatic t_hold;
    int h;
    wait_gate;
    hold = 1;
    h = int'(ctrl);
    off_rx = 40;
    strobe(-15);
    wait_gate; wait_gate;
    chk(int'(err) == 25, "R7 err during hold", int'(err), 25);
    chk(int'(ctrl) == h, "R7 frozen", int'(ctrl), h);
    @(negedge clk);
    hold = 0;
    @(negedge clk);
    chk(int'(ctrl) == satb(exp_i - 15), "R7 resume", int'(ctrl), satb(exp_i - 15));
    off_rx = 0;
    strobe(0);
    wait_gate;
  endtask

  task automatic t_lock;
    wait_gate;
    off_tx = 3;
    @(negedge clk);
    chk(!locked, "R9 offset change clears", int'(locked), 0);
    for (int i = 0; i < 2; i++) begin
      wait_gate; @(negedge clk);
      chk(!locked, "R8 not yet locked", int'(locked), 0);
    end
    wait_gate; @(negedge clk);
    chk(locked, "R8 locked after three", int'(locked), 1);
    per = 12;
    wait_gate; wait_gate;
    chk(int'(err) == 10, "R8 large err", int'(err), 10);
    @(negedge clk);
    chk(!locked, "R8 bad window clears", int'(locked), 0);
    per = 8;
    repeat (4) wait_gate;
    @(negedge clk);
    chk(locked, "R8 relock", int'(locked), 1);
    tx_mode = 1;
    @(negedge clk);
    chk(!locked, "R9 mode change clears", int'(locked), 0);
    tx_mode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_measure;
    t_integrate;
    t_offset;
    t_saturate;
    t_mod;
    t_hold;
    t_lock;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule